// File: doc/BRIEF.md
# Reclocker Lock Qualifier and Output Mute

This block decides whether a clock-and-data-recovery loop is truly locked to its incoming serial stream and gates the retimed outputs from that decision. It watches the retimed bit stream on the recovered clock and takes the loop's own phase-lock flag. It also uses a slow, free-running reference clock to time its observation windows. Lock is granted only when three conditions all hold. Bit transitions keep arriving. The loop reports phase lock. Isolated-bit patterns (`010` or `101`) keep appearing, which proves the loop is not running at twice the bit rate. A loop locked to a harmonic samples every bit twice, so it can only produce doubled patterns such as `110011`.

While lock is absent, the retimed data output is frozen at its last value, so noise is never passed downstream. The clock-output enable follows its own input and does not depend on lock. Short dropouts are absorbed on purpose. A gap in transitions shorter than the data window never drops lock. A lasting loss of signal mutes the output after a bounded delay.

Recovered-clock events are stretched into levels. Each level is then carried into the reference domain through a two-flop synchronizer, where it restarts a window counter. `STRETCH` must cover at least three reference periods in recovered-clock cycles.

Top module: `reclk_lock_guard`

## Requirements
- R1: During and right after reset, `lock` is 0, `mute` is 1, `sdo` is 0 and `sco_en` is 0.
- R2: `lock` rises only after data activity, phase lock and isolated-bit activity have all held together for QUAL_WIN reference cycles. When valid data and phase lock are applied from an unlocked state, `lock` rises no sooner than QUAL_WIN and no later than QUAL_WIN+15 reference cycles later.
- R3: When `pll_locked` falls, `lock` falls within 4 reference cycles. It stays 0 while `pll_locked` is low, even with valid data present.
- R4: After the last transition on `din`, `lock` falls no sooner than DATA_WIN reference cycles later. It falls no later than DATA_WIN + STRETCH/(clock ratio) + 10 reference cycles later.
- R5: A gap without transitions on `din` that is shorter than DATA_WIN reference cycles does not clear `lock`.
- R6: A stream in which every bit is doubled (`1100` repeated) never produces `lock`. If this stream replaces valid data while locked, `lock` falls between HARM_WIN and HARM_WIN+20 reference cycles later.
- R7: A mostly doubled stream that carries at least one `101` or `010` pattern in every HARM_WIN reference cycles keeps `lock` set.
- R8: While `mute` is 0, `sdo` equals the `din` bit sampled two recovered-clock edges earlier.
- R9: While `mute` is 1, `sdo` holds its value whatever `din` does.
- R10: `mute` is the inverse of `lock`, following it within 3 recovered-clock cycles.
- R11: `sco_en` equals `clk_en` delayed by one recovered-clock edge, regardless of `lock` or `mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow free-running reference clock that times all windows |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| rec_clk | input | 1 | Recovered bit clock from the loop |
| rec_rst | input | 1 | Synchronous active-high reset, recovered-clock domain |
| din | input | 1 | Retimed serial bit, one per recovered-clock cycle |
| pll_locked | input | 1 | Phase-lock flag from the loop, asynchronous to ref_clk |
| clk_en | input | 1 | Serial clock output request (1 = enable) |
| lock | output | 1 | Qualified lock indication, reference domain |
| mute | output | 1 | 1 = data output frozen, recovered-clock domain |
| sdo | output | 1 | Retimed data output, held while muted |
| sco_en | output | 1 | Serial clock output enable |

## Verification
The assertions assume that each reset is held for several cycles of its own clock. They also assume that `din` and `clk_en` change only away from the recovered-clock rising edge, and that `pll_locked` is treated as asynchronous to both clocks. The bench starts the recovered clock with a phase offset, so no recovered edge coincides with a reference edge. It drives `din` on recovered falling edges and drives all other inputs on reference falling edges. The bench also chooses STRETCH to span more than three reference periods. This keeps every isolated pattern and every transition visible to the reference-domain synchronizer.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  // events detected on the recovered-clock bit stream
  typedef enum int {EV_EDGE = 0, EV_ISO = 1} ev_idx_e;
  localparam int NUM_EV = 2;

  // bits needed to hold the value n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lkd_sync.sv
module lkd_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/lkd_bit_monitor.sv
module lkd_bit_monitor #(
  parameter int STRETCH = 24
) (
  input  logic                      rec_clk,
  input  logic                      rec_rst,
  input  logic                      din,
  output logic                      bit_q,
  output logic [lkd_pkg::NUM_EV-1:0] ev_lvl
);
  import lkd_pkg::*;
  localparam int SW = cnt_w(STRETCH);
  localparam logic [SW-1:0] SLIM = SW'(STRETCH);

  logic [2:0] sr_q;
  logic [NUM_EV-1:0] ev;

  always_ff @(posedge rec_clk) begin
    if (rec_rst) sr_q <= '0;
    else         sr_q <= {sr_q[1:0], din};
  end

  always_comb begin
    ev          = '0;
    ev[EV_EDGE] = sr_q[1] ^ sr_q[0];
    ev[EV_ISO]  = (sr_q == 3'b101) || (sr_q == 3'b010);
  end

  assign bit_q = sr_q[0];

  // stretch each single-cycle event into a level the slow domain can see
  for (genvar i = 0; i < NUM_EV; i++) begin : g_stretch
    logic [SW-1:0] cnt_q;
    logic          lvl_q;
    always_ff @(posedge rec_clk) begin
      if (rec_rst) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else begin
        if (ev[i])              cnt_q <= SLIM;
        else if (cnt_q != '0)   cnt_q <= cnt_q - SW'(1);
        lvl_q <= ev[i] || (cnt_q != '0);
      end
    end
    assign ev_lvl[i] = lvl_q;
  end
endmodule

// File: rtl/lkd_window.sv
module lkd_window #(
  parameter int WIN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic ok
);
  localparam int CW = lkd_pkg::cnt_w(WIN);
  localparam logic [CW-1:0] LIM = CW'(WIN);

  logic [CW-1:0] cnt_q;

  // starts expired; any activity restarts it, a full quiet window expires it
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= LIM;
    else if (activity)      cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + CW'(1);
  end

  assign ok = (cnt_q != LIM);
endmodule

// File: rtl/reclk_lock_guard.sv
module reclk_lock_guard #(
  parameter int DATA_WIN = 20,
  parameter int HARM_WIN = 3000,
  parameter int QUAL_WIN = 3000,
  parameter int STRETCH  = 24
) (
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic rec_clk,
  input  logic rec_rst,
  input  logic din,
  input  logic pll_locked,
  input  logic clk_en,
  output logic lock,
  output logic mute,
  output logic sdo,
  output logic sco_en
);
  import lkd_pkg::*;
  localparam int QW = cnt_w(QUAL_WIN);
  localparam logic [QW-1:0] QLIM = QW'(QUAL_WIN);

  // ---------------- recovered-clock side ----------------
  logic              bit_q;
  logic [NUM_EV-1:0] ev_lvl;

  lkd_bit_monitor #(.STRETCH(STRETCH)) u_mon (
    .rec_clk (rec_clk),
    .rec_rst (rec_rst),
    .din     (din),
    .bit_q   (bit_q),
    .ev_lvl  (ev_lvl)
  );

  // ---------------- reference-clock side ----------------
  logic [2:0] ref_s;
  logic       ph_ok, data_ok, harm_ok, all_ok;
  logic [QW-1:0] qual_q;
  logic       lock_q;

  lkd_sync #(.W(3)) u_ref_sync (
    .clk (ref_clk),
    .rst (ref_rst),
    .d   ({pll_locked, ev_lvl[EV_ISO], ev_lvl[EV_EDGE]}),
    .q   (ref_s)
  );

  assign ph_ok = ref_s[2];

  lkd_window #(.WIN(DATA_WIN)) u_data_win (
    .clk      (ref_clk),
    .rst      (ref_rst),
    .activity (ref_s[0]),
    .ok       (data_ok)
  );

  lkd_window #(.WIN(HARM_WIN)) u_harm_win (
    .clk      (ref_clk),
    .rst      (ref_rst),
    .activity (ref_s[1]),
    .ok       (harm_ok)
  );

  assign all_ok = data_ok && harm_ok && ph_ok;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      qual_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!all_ok)            qual_q <= '0;
      else if (qual_q != QLIM) qual_q <= qual_q + QW'(1);
      lock_q <= all_ok && (qual_q == QLIM);
    end
  end

  assign lock = lock_q;

  // ---------------- back to recovered clock: mute and outputs ----------------
  logic locked_rc;
  logic mute_q, sdo_q, sco_en_q;

  lkd_sync #(.W(1)) u_rec_sync (
    .clk (rec_clk),
    .rst (rec_rst),
    .d   (lock_q),
    .q   (locked_rc)
  );

  always_ff @(posedge rec_clk) begin
    if (rec_rst) begin
      mute_q   <= 1'b1;
      sdo_q    <= 1'b0;
      sco_en_q <= 1'b0;
    end else begin
      mute_q   <= !locked_rc;
      if (!mute_q) sdo_q <= bit_q;
      sco_en_q <= clk_en;
    end
  end

  assign mute   = mute_q;
  assign sdo    = sdo_q;
  assign sco_en = sco_en_q;
endmodule

// File: rtl/reclk_lock_guard_chk.sv
module reclk_lock_guard_chk (
  input logic ref_clk,
  input logic ref_rst,
  input logic rec_clk,
  input logic rec_rst,
  input logic clk_en,
  input logic lock,
  input logic mute,
  input logic sdo,
  input logic sco_en,
  input logic bit_q,
  input logic ph_ok,
  input logic data_ok,
  input logic harm_ok
);
  // R2: lock only follows a cycle where both activity windows were satisfied
  a_r2_lock_needs_windows: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (lock && !$past(ref_rst)) |-> ($past(data_ok) && $past(harm_ok)));

  // R3: lock only follows a cycle where the synchronized phase flag was high
  a_r3_lock_needs_phase: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (lock && !$past(ref_rst)) |-> $past(ph_ok));

  // R8: unmuted output follows the captured bit one edge later
  a_r8_follow: assert property (@(posedge rec_clk) disable iff (rec_rst)
    (!$past(rec_rst) && !$past(mute)) |-> (sdo == $past(bit_q)));

  // R9: muted output does not move
  a_r9_hold: assert property (@(posedge rec_clk) disable iff (rec_rst)
    (!$past(rec_rst) && $past(mute)) |-> $stable(sdo));

  // R11: clock enable is the request delayed by one edge
  a_r11_clk_en: assert property (@(posedge rec_clk) disable iff (rec_rst)
    !$past(rec_rst) |-> (sco_en == $past(clk_en)));
endmodule

bind reclk_lock_guard reclk_lock_guard_chk u_chk (
  .ref_clk (ref_clk),
  .ref_rst (ref_rst),
  .rec_clk (rec_clk),
  .rec_rst (rec_rst),
  .clk_en  (clk_en),
  .lock    (lock),
  .mute    (mute),
  .sdo     (sdo),
  .sco_en  (sco_en),
  .bit_q   (bit_q),
  .ph_ok   (ph_ok),
  .data_ok (data_ok),
  .harm_ok (harm_ok)
);

// File: tb/tb_reclk_lock_guard.sv
module tb_reclk_lock_guard;
  localparam int REF_PERIOD = 20;
  localparam int REC_PERIOD = 4;
  localparam int DATA_WIN   = 10;
  localparam int HARM_WIN   = 60;
  localparam int QUAL_WIN   = 60;
  localparam int STRETCH    = 24;
  localparam int SPARSE_PER = 152;

  logic ref_clk = 1'b0, rec_clk = 1'b0;
  logic ref_rst = 1'b1, rec_rst = 1'b1;
  logic din = 1'b0, pll_locked = 1'b0, clk_en = 1'b0;
  logic lock, mute, sdo, sco_en;

  int errors = 0, checks = 0;
  int mode = 0;            // 0 lfsr, 1 doubled, 2 hold, 3 sparse isolated
  logic [6:0] lf = 7'h5A;
  int p = 0;
  logic h1 = 1'b0, h2 = 1'b0;
  bit chk_on = 1'b0;
  int follow_n = 0, follow_bad = 0;

  reclk_lock_guard #(.DATA_WIN(DATA_WIN), .HARM_WIN(HARM_WIN),
                     .QUAL_WIN(QUAL_WIN), .STRETCH(STRETCH)) dut (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .rec_clk(rec_clk), .rec_rst(rec_rst),
    .din(din), .pll_locked(pll_locked), .clk_en(clk_en),
    .lock(lock), .mute(mute), .sdo(sdo), .sco_en(sco_en)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  initial begin
    #1;
    forever #(REC_PERIOD/2) rec_clk = ~rec_clk;
  end

  // stimulus generator and follow monitor
  always @(negedge rec_clk) begin
    logic nb;
    logic [3:0] dbl;
    dbl = 4'b0011;          // index 0,1 -> 1 ; 2,3 -> 0
    if (chk_on) begin
      follow_n++;
      if (sdo !== h2) follow_bad++;
    end
    nb = din;
    case (mode)
      0: begin lf = {lf[5:0], lf[6] ^ lf[5]}; nb = lf[0]; end
      1: nb = ~dbl[p % 4];
      2: nb = din;
      default: begin
        if (p % SPARSE_PER == SPARSE_PER - 2)      nb = 1'b1;
        else if (p % SPARSE_PER == SPARSE_PER - 1) nb = 1'b0;
        else                                        nb = ~dbl[p % 4];
      end
    endcase
    din = nb;
    h2 = h1;
    h1 = nb;
    p++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_lock(input logic want, input int max, output int n);
    n = 0;
    while (lock !== want && n < max) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge ref_clk);
    check(lock === 1'b0, "R1 lock in reset", lock, 0);
    check(mute === 1'b1, "R1 mute in reset", mute, 1);
    check(sdo === 1'b0 && sco_en === 1'b0, "R1 sdo/sco_en in reset", {sdo, sco_en}, 0);
    ref_rst = 1'b0;
    rec_rst = 1'b0;
    @(negedge ref_clk);
    check(lock === 1'b0 && mute === 1'b1, "R1 state after release", {lock, mute}, 1);
  endtask

  task automatic t_doubled_never;
    int hits = 0;
    mode = 1;
    pll_locked = 1'b1;
    repeat (200) begin
      @(negedge ref_clk);
      if (lock) hits++;
    end
    check(hits == 0, "R6 doubled stream never locks", hits, 0);
  endtask

  task automatic t_acquire;
    int n;
    mode = 0;
    pll_locked = 1'b1;
    wait_lock(1'b1, 300, n);
    check(n >= QUAL_WIN && n <= QUAL_WIN + 15, "R2 lock acquisition time", n, QUAL_WIN);
    repeat (2) @(negedge ref_clk);
    check(mute === 1'b0, "R10 mute clears after lock", mute, 0);
  endtask

  task automatic t_follow;
    follow_n = 0;
    follow_bad = 0;
    chk_on = 1'b1;
    repeat (50) @(negedge ref_clk);
    chk_on = 1'b0;
    check(follow_bad == 0 && follow_n > 0, "R8 sdo follows din", follow_bad, 0);
  endtask

  task automatic t_short_gap;
    int drops = 0;
    for (int k = 0; k < 3; k++) begin
      mode = 2;
      repeat (6) begin
        @(negedge ref_clk);
        if (!lock) drops++;
      end
      mode = 0;
      repeat (20) begin
        @(negedge ref_clk);
        if (!lock) drops++;
      end
    end
    check(drops == 0, "R5 short gaps keep lock", drops, 0);
  endtask

  task automatic t_sparse;
    int drops = 0;
    mode = 3;
    repeat (250) begin
      @(negedge ref_clk);
      if (!lock) drops++;
    end
    check(drops == 0, "R7 sparse isolated patterns keep lock", drops, 0);
    mode = 0;
    repeat (5) @(negedge ref_clk);
  endtask

  task automatic t_harm_loss;
    int n;
    mode = 1;
    wait_lock(1'b0, 200, n);
    check(n >= HARM_WIN && n <= HARM_WIN + 20, "R6 harmonic loss time", n, HARM_WIN);
  endtask

  task automatic t_reacquire;
    int n;
    mode = 0;
    pll_locked = 1'b1;
    wait_lock(1'b1, 300, n);
    check(n >= QUAL_WIN && n <= QUAL_WIN + 15, "R2 relock time", n, QUAL_WIN);
    repeat (3) @(negedge ref_clk);
  endtask

  task automatic t_removal;
    int n, moves = 0;
    logic held;
    mode = 2;
    wait_lock(1'b0, 200, n);
    check(n >= DATA_WIN && n <= DATA_WIN + 16, "R4 loss-of-data time", n, DATA_WIN);
    @(negedge ref_clk);
    check(mute === 1'b1, "R10 mute after lock loss", mute, 1);
    pll_locked = 1'b0;
    held = sdo;
    mode = 0;
    repeat (40) begin
      @(negedge ref_clk);
      if (sdo !== held) moves++;
    end
    check(moves == 0 && mute === 1'b1, "R9 sdo held while muted", moves, 0);
  endtask

  task automatic t_phase;
    int n, hits = 0;
    pll_locked = 1'b0;
    wait_lock(1'b0, 50, n);
    check(n <= 4, "R3 phase loss drops lock", n, 4);
    repeat (100) begin
      @(negedge ref_clk);
      if (lock) hits++;
    end
    check(hits == 0, "R3 no lock without phase flag", hits, 0);
  endtask

  task automatic t_clken(input logic v);
    @(negedge ref_clk);
    clk_en = v;
    @(posedge rec_clk);
    @(negedge rec_clk);
    check(sco_en === v, "R11 sco_en follows clk_en", sco_en, v);
  endtask

  initial begin
    repeat (20000) @(posedge ref_clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_doubled_never();
    t_acquire();
    t_follow();
    t_clken(1'b1);
    t_short_gap();
    t_sparse();
    t_harm_loss();
    t_reacquire();
    t_removal();
    t_clken(1'b0);
    t_clken(1'b1);
    t_reacquire();
    t_phase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule